// File: doc/BRIEF.md
# Escalating Multi-Core Watchdog

This block gives every core of a chip its own watchdog timer. Each one escalates instead of resetting the chip at once. Software arms a watchdog by writing a control word that holds a 16-bit length and a 2-bit escalation mode. The length fills the upper bits of a down-counter whose lower bits start at zero. A shared free-running prescaler steps that counter. Each time the counter runs out, the watchdog reloads itself and moves up one stage:

- first an interrupt level,
- then a non-maskable interrupt level,
- then a one-cycle request for a chip-wide soft reset.

The mode field sets the highest stage a watchdog may reach.

A live core keeps its watchdog quiet by strobing the poke input for that core. A poke reloads the counter and drops the watchdog back to idle. Any core's status can be read back through a selected readback word. In that word, bit 1 shows that the NMI stage has been reached, so an NMI handler can tell a watchdog NMI apart from any other NMI. The reset requests of all instances merge into one output.

Top module: `wdog_escalator`

## Requirements
- R1: After reset every instance is disarmed: mode 0, length 0, stage idle. All interrupt, NMI and reset outputs are low and every readback word is zero.
- R2: A control write loads the counter with the length in its upper LEN_W bits and zeros in its lower LOW_W bits. The counter moves one step on every prescaler tick, and the prescaler ticks once every 2^PRESC_W clocks. An expiry happens on the tick that finds the counter at 1, so one period is length × 2^LOW_W ticks. With the default parameters that is length × 65536 clocks.
- R3: In mode 3 the first expiry raises the core's interrupt output, the second raises its NMI output, and the third requests a soft reset. Each output changes on the clock edge of its expiry.
- R4: Mode 1 stops at the interrupt stage and mode 2 stops at the NMI stage. Later expiries reload the counter and change no output, and the highest enabled output stays asserted.
- R5: A poke strobe for a core reloads its counter from the stored length and returns it to idle on the next edge, which clears its interrupt and NMI outputs. A poke takes priority over an expiry in the same cycle.
- R6: A control write to a core loads the new mode and length, reloads its counter and returns it to idle on the same edge.
- R7: An instance whose mode is 0 or whose length is 0 never asserts any output.
- R8: The readback word for the core chosen by `rdCore` has this layout: bit 0 = interrupt stage reached, bit 1 = NMI stage reached, bits 3:2 = mode, bits 19:4 = length.
- R9: The soft reset request is a one-cycle pulse issued once per escalation. The requests of all instances are ORed onto a single output.
- R10: Instances are independent. A write or poke aimed at one core leaves the state and outputs of every other core unchanged.
- R11: The interrupt and NMI outputs are levels. They stay asserted until that core sees a poke or a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control-word write strobe |
| cfgWrCore | input | CORE_W | Core selected by the write |
| cfgWrMode | input | 2 | Escalation mode to write (0 off, 1 irq, 2 irq+nmi, 3 irq+nmi+reset) |
| cfgWrLen | input | LEN_W | Period length to write |
| pokeVec | input | NUM_CORES | Per-core poke strobes |
| rdCore | input | CORE_W | Core whose readback word is shown |
| rdWord | output | LEN_W+4 | Readback word of the selected core |
| irqVec | output | NUM_CORES | Per-core interrupt levels |
| nmiVec | output | NUM_CORES | Per-core NMI levels |
| softResetReq | output | 1 | Merged one-cycle soft reset request |

## Verification
Writes and pokes act on the first rising edge after they are driven. Expiry effects appear on the edge of the expiring tick, and `rdWord` follows `rdCore` combinationally. The bench drives its inputs 2 ns after a falling edge. It keeps a cycle-based reference model that it updates on every rising edge and compares against on every falling edge, so every output is checked in the exact cycle it is due. The directed timing checks count falling edges from the write edge:

- The first interrupt is allowed a window of 13 to 16 edges, which covers the unknown prescaler phase.
- Once the tick phase is fixed, the later stages must follow exactly one period apart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    STG_IDLE  = 2'd0,
    STG_IRQ   = 2'd1,
    STG_NMI   = 2'd2,
    STG_RESET = 2'd3
  } stage_t;

  // Strobes from the stage control to the count datapath.
  typedef struct packed {
    logic reload;
    logic step;
  } cnt_strobe_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRESC_W = 8
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  logic [PRESC_W-1:0] prescCnt;

  always_ff @(posedge clk) begin
    if (!rstN) prescCnt <= '0;
    else       prescCnt <= prescCnt + 1'b1;
  end

  assign tick = &prescCnt;
endmodule

// File: rtl/wdog_count_path.sv
module wdog_count_path
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [LEN_W-1:0]  wrLen,
  input  cnt_strobe_t       strobe,
  output logic [MODE_W-1:0] modeQ,
  output logic [LEN_W-1:0]  lenQ,
  output logic              armed,
  output logic              expireDue
);
  localparam int CNT_W = LEN_W + LOW_W;

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      lenQ  <= '0;
      cntQ  <= '0;
    end else if (cfgWr) begin
      modeQ <= wrMode;
      lenQ  <= wrLen;
      cntQ  <= {wrLen, {LOW_W{1'b0}}};
    end else if (strobe.reload) begin
      cntQ  <= {lenQ, {LOW_W{1'b0}}};
    end else if (strobe.step) begin
      cntQ  <= cntQ - 1'b1;
    end
  end

  assign armed     = (modeQ != '0) && (lenQ != '0);
  assign expireDue = (cntQ == CNT_W'(1));

  // R2: a step moves the counter down by exactly one
  assert_step_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (cntQ == $past(cntQ) - 1'b1));

  // R2: a reload without a write restores length in the upper bits
  assert_reload_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !cfgWr) |=> (cntQ == {$past(lenQ), {LOW_W{1'b0}}}));
endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              poke,
  input  logic              tick,
  input  logic              armed,
  input  logic              expireDue,
  input  logic [MODE_W-1:0] modeQ,
  output cnt_strobe_t       strobe,
  output stage_t            stage,
  output logic              irqLvl,
  output logic              nmiLvl,
  output logic              resetPulse
);
  logic   restart;
  logic   expire;
  logic   canAdvance;
  stage_t stageNext;

  assign restart    = cfgWr | poke;
  assign expire     = tick && armed && expireDue && !restart;
  assign canAdvance = (2'(stage) < modeQ);

  always_comb begin
    strobe.reload = restart | expire;
    strobe.step   = tick && armed && !expireDue && !restart;
  end

  always_comb begin
    stageNext = stage;
    if (restart)                  stageNext = STG_IDLE;
    else if (expire && canAdvance) stageNext = stage_t'(2'(stage) + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage      <= STG_IDLE;
      resetPulse <= 1'b0;
    end else begin
      stage      <= stageNext;
      resetPulse <= expire && canAdvance && (stage == STG_NMI);
    end
  end

  assign irqLvl = (stage != STG_IDLE);
  assign nmiLvl = (stage == STG_NMI) || (stage == STG_RESET);

  // R4: the stage never goes past the mode limit
  assert_mode_limit_R4: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (2'(stage) <= modeQ));

  // R3: without a restart the stage holds or climbs by one
  assert_stage_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !restart |=> ((stage == $past(stage)) ||
                  (2'(stage) == 2'(2'($past(stage)) + 2'd1))));

  // R5 / R6: a poke or write leaves the instance idle
  assert_restart_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (stage == STG_IDLE));

  // R9: the reset request lasts a single cycle
  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> !resetPulse);

  // R7: a disarmed instance keeps all outputs low
  assert_quiet_disarmed_R7: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!irqLvl && !nmiLvl && !resetPulse));
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int LEN_W     = 16,
  parameter int LOW_W     = 8,
  parameter int PRESC_W   = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int RD_W     = LEN_W + 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CORE_W-1:0]    cfgWrCore,
  input  logic [MODE_W-1:0]    cfgWrMode,
  input  logic [LEN_W-1:0]     cfgWrLen,
  input  logic [NUM_CORES-1:0] pokeVec,
  input  logic [CORE_W-1:0]    rdCore,
  output logic [RD_W-1:0]      rdWord,
  output logic [NUM_CORES-1:0] irqVec,
  output logic [NUM_CORES-1:0] nmiVec,
  output logic                 softResetReq
);
  logic                 tick;
  logic [NUM_CORES-1:0] pulseVec;
  logic [RD_W-1:0]      statusWord [NUM_CORES];

  wdog_prescale #(.PRESC_W(PRESC_W)) u_presc (
    .clk  (clk),
    .rstN (rstN),
    .tick (tick)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic              coreWr;
    cnt_strobe_t       strobe;
    stage_t            stage;
    logic [MODE_W-1:0] modeQ;
    logic [LEN_W-1:0]  lenQ;
    logic              armed;
    logic              expireDue;

    assign coreWr = cfgWrEn && (cfgWrCore == CORE_W'(g));

    wdog_count_path #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_path (
      .clk       (clk),
      .rstN      (rstN),
      .cfgWr     (coreWr),
      .wrMode    (cfgWrMode),
      .wrLen     (cfgWrLen),
      .strobe    (strobe),
      .modeQ     (modeQ),
      .lenQ      (lenQ),
      .armed     (armed),
      .expireDue (expireDue)
    );

    wdog_stage_ctrl u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .cfgWr      (coreWr),
      .poke       (pokeVec[g]),
      .tick       (tick),
      .armed      (armed),
      .expireDue  (expireDue),
      .modeQ      (modeQ),
      .strobe     (strobe),
      .stage      (stage),
      .irqLvl     (irqVec[g]),
      .nmiLvl     (nmiVec[g]),
      .resetPulse (pulseVec[g])
    );

    assign statusWord[g] = {lenQ, modeQ, nmiVec[g], irqVec[g]};
  end

  always_comb begin
    rdWord = '0;
    if (int'(rdCore) < NUM_CORES) rdWord = statusWord[rdCore];
  end

  assign softResetReq = |pulseVec;

  // R8: readback bit 1 agrees with the selected core's NMI output
  assert_readback_nmi_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdWord[1] |-> nmiVec[rdCore]);
endmodule

// File: tb/wdog_escalator_bench.sv
`timescale 1ns/1ps
module wdog_escalator_bench;
  localparam int NC = 2;
  localparam int LW = 16;
  localparam int LOW = 2;
  localparam int PW = 2;
  localparam int PMAX = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [0:0]    cfgWrCore = '0;
  logic [1:0]    cfgWrMode = '0;
  logic [LW-1:0] cfgWrLen = '0;
  logic [NC-1:0] pokeVec = '0;
  logic [0:0]    rdCore = '0;
  logic [LW+3:0] rdWord;
  logic [NC-1:0] irqVec;
  logic [NC-1:0] nmiVec;
  logic          softResetReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  int mMode[NC];
  int mLen[NC];
  int mLeft[NC];
  int mStage[NC];
  int mPresc;
  bit mPulse;
  bit tickNow;
  bit pulseNow;

  always #10 clk = ~clk;

  wdog_escalator #(.NUM_CORES(NC), .LEN_W(LW), .LOW_W(LOW), .PRESC_W(PW)) u_wdog_escalator (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrCore(cfgWrCore),
    .cfgWrMode(cfgWrMode), .cfgWrLen(cfgWrLen), .pokeVec(pokeVec),
    .rdCore(rdCore), .rdWord(rdWord), .irqVec(irqVec), .nmiVec(nmiVec),
    .softResetReq(softResetReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expWord(input int c);
    return (mLen[c] << 4) | (mMode[c] << 2) | ((mStage[c] >= 2) ? 2 : 0) | ((mStage[c] >= 1) ? 1 : 0);
  endfunction

  // Model from the requirements: period = len * 2^LOW ticks, tick when prescaler is at its top value
  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NC; c++) begin
        mMode[c] = 0; mLen[c] = 0; mLeft[c] = 0; mStage[c] = 0;
      end
      mPresc = 0;
      mPulse = 0;
    end else begin
      tickNow = (mPresc == PMAX);
      mPresc = (mPresc + 1) & PMAX;
      pulseNow = 0;
      for (int c = 0; c < NC; c++) begin
        if (cfgWrEn && int'(cfgWrCore) == c) begin
          mMode[c] = int'(cfgWrMode);
          mLen[c] = int'(cfgWrLen);
          mLeft[c] = mLen[c] << LOW;
          mStage[c] = 0;
        end else if (pokeVec[c]) begin
          mLeft[c] = mLen[c] << LOW;
          mStage[c] = 0;
        end else if (tickNow && mMode[c] != 0 && mLen[c] != 0) begin
          if (mLeft[c] == 1) begin
            mLeft[c] = mLen[c] << LOW;
            if (mStage[c] < mMode[c]) begin
              mStage[c]++;
              if (mStage[c] == 3) pulseNow = 1;
            end
          end else begin
            mLeft[c]--;
          end
        end
      end
      mPulse = pulseNow;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int c = 0; c < NC; c++) begin
        check("R3 irq level (R11)", int'(irqVec[c]), (mStage[c] >= 1) ? 1 : 0);
        check("R3 nmi level (R4)", int'(nmiVec[c]), (mStage[c] >= 2) ? 1 : 0);
      end
      check("R9 soft reset pulse", int'(softResetReq), int'(mPulse));
      check("R8 readback word", int'(rdWord), expWord(int'(rdCore)));
    end
  end

  task automatic doWrite(input int core, input int mode, input int len);
    @(negedge clk); #2;
    cfgWrEn = 1'b1; cfgWrCore = 1'(core); cfgWrMode = 2'(mode); cfgWrLen = LW'(len);
    @(negedge clk); #2;
    cfgWrEn = 1'b0;
  endtask

  task automatic doPoke(input int core);
    @(negedge clk); #2;
    pokeVec[core] = 1'b1;
    @(negedge clk); #2;
    pokeVec = '0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1: actual hung expected done");
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NC; c++) begin
      rdCore = 1'(c); #1;
      check("R1 readback zero", int'(rdWord), 0);
    end
    check("R1 irq low", int'(irqVec), 0);
    check("R1 nmi low", int'(nmiVec), 0);
    check("R1 reset low", int'(softResetReq), 0);

    // R2: first expiry window then exact period spacing, mode 3 escalation (R3)
    doWrite(0, 3, 1);
    n = 0;
    while (!irqVec[0] && n < 100) begin @(negedge clk); n++; end
    check("R2 first expiry in window", (n >= 13 && n <= 16) ? 1 : 0, 1);
    n = 0;
    while (!nmiVec[0] && n < 100) begin @(negedge clk); n++; end
    check("R2 R3 nmi one period later", n, 16);
    n = 0;
    while (!softResetReq && n < 100) begin @(negedge clk); n++; end
    check("R3 reset one period after nmi", n, 16);
    @(negedge clk);
    check("R9 pulse width one cycle", int'(softResetReq), 0);

    // R4: mode 1 stops at the interrupt stage; R11 level holds
    doWrite(1, 1, 1);
    waitCycles(120);
    check("R4 mode1 irq held", int'(irqVec[1]), 1);
    check("R4 mode1 no nmi", int'(nmiVec[1]), 0);
    check("R11 core0 nmi still held", int'(nmiVec[0]), 1);

    // R8: readback layout of core 0 (len 1, mode 3, both stage bits)
    #2 rdCore = 1'b0; #1;
    check("R8 readback core0", int'(rdWord), (1 << 4) | (3 << 2) | 3);

    // R5 / R10: poke core 0, core 1 untouched
    doPoke(0);
    check("R5 poke clears irq", int'(irqVec[0]), 0);
    check("R5 poke clears nmi", int'(nmiVec[0]), 0);
    check("R10 other core kept", int'(irqVec[1]), 1);

    // R6: rewriting core 1 clears its stage
    doWrite(1, 1, 1);
    check("R6 write clears irq", int'(irqVec[1]), 0);

    // R7: zero length or zero mode never asserts
    doWrite(0, 3, 0);
    doWrite(1, 0, 5);
    waitCycles(200);
    check("R7 len0 quiet", int'(irqVec[0]), 0);
    check("R7 mode0 quiet", int'(irqVec[1]), 0);
    #2 rdCore = 1'b1; #1;
    check("R7 R8 mode0 readback", int'(rdWord), 5 << 4);

    // random mix of writes, pokes and reads
    for (int i = 0; i < 5000; i++) begin
      int r;
      @(negedge clk); #2;
      cfgWrEn = 1'b0; pokeVec = '0;
      r = int'($urandom % 100);
      if (r < 3) begin
        cfgWrEn = 1'b1; cfgWrCore = 1'($urandom % NC);
        cfgWrMode = 2'($urandom % 4); cfgWrLen = LW'($urandom % 4);
      end else if (r < 6) begin
        pokeVec[$urandom % NC] = 1'b1;
      end
      rdCore = 1'($urandom % NC);
    end
    @(negedge clk); #2;
    cfgWrEn = 1'b0; pokeVec = '0;
    waitCycles(4);
    summary();
  end
endmodule